// File: doc/BRIEF.md
# Masked Vector Element Engine

This block walks the elements of one destination vector register group, one element per clock, and rewrites it in place. Elements before the start index are left alone. Elements between the start index and the vector length form the body. Each body element is either computed from its source elements or, when its mask bit is clear and masking is enabled, treated as masked-off. Elements from the vector length up to the group's total element count form the tail. Masked-off and tail elements are either left as they were or filled with all-ones, each under its own policy bit.

The total element count comes from the register size in bytes, the element width, the selected element width and a signed group-multiplier code. The effective multiplier exponent is clamped into range, so a fractional group still processes the whole register as tail past its last body element. A job is handed over in one transfer: the configuration, a scalar, the mask and the flattened source and old-destination groups. The request side uses valid/ready. `req_ready` is high only while the engine is idle, a request is taken on a clock edge where both are high, and a held request simply waits while the engine is busy. Completion is signalled by plain one-cycle pulses. The rewritten group on `vd_out` stays stable until the next request is taken.

Top module: `vpol_engine`

## Requirements
- R1: `req_ready` is 1 exactly when the engine is idle (including the cycle in which `done` is high). A request is taken on an edge with `req_valid` and `req_ready` both high, and all inputs are sampled on that edge. While idle with no request taken, `vd_out` does not change.
- R2: For a legal job with total count T and start index S, the number of processed elements is N = T-S when S<T and 0 otherwise. `done` is high for exactly one cycle, N+1 clock edges after the accepting edge. `req_ready` is low in between.
- R3: `vstart_clr` pulses together with `done` on every legal job. Elements with index below `cfg_vstart` keep their old value.
- R4: An active body element gets the result of `cfg_op`, computed modulo 2^(8·element bytes). Code 0 copies vs2. Code 1 gives vs2+vs1. Code 2 gives vs2−vs1. Code 3 gives vs2 minus the scalar, where the scalar is first truncated to the element width.
- R5: The mask bit of element i is bit i of `mask_in`, which is bit i mod 64 of 64-bit word i div 64. With `cfg_vm`=1 every body element is active. A masked-off body element becomes all-ones when `cfg_vma`=1 and keeps its old value when `cfg_vma`=0.
- R6: Elements from index `cfg_vl` up to T−1 are tail. They become all-ones when `cfg_vta`=1 and keep their old value when `cfg_vta`=0.
- R7: `cfg_lmul` is a signed log2 code. Codes 0..3 select ×1..×8 and codes 5,6,7 select ×1/8, ×1/4, ×1/2. The total count is T = (VLENB << e) >> `cfg_esz_l`, where e = `cfg_esz_l` − `cfg_sew_l` + lmul, clamped to the range 0..MAX_LMUL_L.
- R8: `cfg_esz_l` and `cfg_sew_l` give log2 of a byte count: 0..3 mean 1, 2, 4 and 8 bytes. Element i occupies bytes i·n to i·n+n−1 of the group, least significant byte first. Group byte b sits at bits 8b+7:8b of the flat vectors.
- R9: Lmul code 4 is reserved. Such a job raises `cfg_illegal`, leaves every destination byte unchanged, and gives `done` one edge after acceptance with no `vstart_clr`. `cfg_illegal` holds until the next request is taken.
- R10: When `cfg_vstart` ≥ `cfg_vl`, no element is computed, but the elements from `cfg_vstart` to T−1 still follow the tail policy.
- R11: After reset, `req_ready`=1, `done`=0, `vstart_clr`=0, `cfg_illegal`=0 and `vd_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Job request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| cfg_vstart | input | IDXW | First element index to process |
| cfg_vl | input | IDXW | Vector length (end of body) |
| cfg_vm | input | 1 | 1: masking disabled |
| cfg_vma | input | 1 | Masked-off policy: 1 fills all-ones |
| cfg_vta | input | 1 | Tail policy: 1 fills all-ones |
| cfg_lmul | input | 3 | Signed log2 group multiplier code |
| cfg_sew_l | input | 2 | log2 of selected element bytes |
| cfg_esz_l | input | 2 | log2 of operated element bytes |
| cfg_op | input | 2 | Operation code |
| scalar_in | input | 64 | Scalar operand |
| mask_in | input | MAX_ELEMS | Flat mask, one bit per element |
| vs1_in | input | 8·GRP_BYTES | First source group |
| vs2_in | input | 8·GRP_BYTES | Second source group |
| vd_in | input | 8·GRP_BYTES | Old destination group |
| vd_out | output | 8·GRP_BYTES | Rewritten destination group |
| done | output | 1 | One-cycle completion pulse |
| vstart_clr | output | 1 | Start index may be cleared |
| cfg_illegal | output | 1 | Last job used the reserved code |

## Verification
The completion pulse and the taking of a new request can fall in the same cycle, because `req_ready` is already high while `done` is. The bench provokes this by raising `req_valid` in the very cycle it observes `done`. It judges the overlap in two ways. First, the finished job's group, read in that cycle, must match the model. Second, the new job's own latency and result must be exact, which shows that the new operands replaced the old group at the accepting edge and that the pulse did not leak into the new job.

// File: rtl/vpol_pkg.sv
package vpol_pkg;
  typedef enum logic [1:0] {
    OP_COPY = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_SUBX = 2'd3
  } vpol_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } vpol_state_e;

  localparam logic [2:0] LMUL_RESERVED = 3'b100;

  function automatic logic [63:0] width_mask(input logic [1:0] esz_l);
    logic [63:0] m;
    case (esz_l)
      2'd0:    m = 64'h0000_0000_0000_00FF;
      2'd1:    m = 64'h0000_0000_0000_FFFF;
      2'd2:    m = 64'h0000_0000_FFFF_FFFF;
      default: m = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/vpol_geom.sv
module vpol_geom #(
  parameter int VLENB      = 16,
  parameter int MAX_LMUL_L = 3,
  parameter int IDXW       = 8
) (
  input  logic [2:0]      lmul,
  input  logic [1:0]      sew_l,
  input  logic [1:0]      esz_l,
  output logic [IDXW-1:0] total,
  output logic            illegal
);
  import vpol_pkg::*;

  int lmul_s;
  int emul_raw;
  int emul_c;
  int bytes_grp;

  always_comb begin
    lmul_s   = lmul[2] ? int'(lmul) - 8 : int'(lmul);
    emul_raw = int'(esz_l) - int'(sew_l) + lmul_s;
    if (emul_raw < 0)               emul_c = 0;
    else if (emul_raw > MAX_LMUL_L) emul_c = MAX_LMUL_L;
    else                            emul_c = emul_raw;
    bytes_grp = VLENB << emul_c;
    total     = IDXW'(bytes_grp >> esz_l);
    illegal   = (lmul == LMUL_RESERVED);
  end
endmodule

// File: rtl/vpol_lane.sv
module vpol_lane (
  input  logic [63:0] a_el,
  input  logic [63:0] b_el,
  input  logic [63:0] scalar,
  input  logic [1:0]  op,
  input  logic [1:0]  esz_l,
  input  logic        in_body,
  input  logic        el_active,
  input  logic        vma,
  input  logic        vta,
  output logic        wr_en,
  output logic [63:0] wdata
);
  import vpol_pkg::*;

  logic [63:0] wmask;
  logic [63:0] res;
  logic        fill;

  always_comb begin
    wmask = width_mask(esz_l);
    case (vpol_op_e'(op))
      OP_COPY: res = a_el;
      OP_ADD:  res = a_el + b_el;
      OP_SUB:  res = a_el - b_el;
      default: res = a_el - (scalar & wmask);
    endcase
    res = res & wmask;
    if (in_body) begin
      fill  = !el_active && vma;
      wr_en = el_active || vma;
    end else begin
      fill  = vta;
      wr_en = vta;
    end
    wdata = fill ? 64'hFFFF_FFFF_FFFF_FFFF : res;
  end
endmodule

// File: rtl/vpol_seq.sv
module vpol_seq #(
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            illegal,
  input  logic [IDXW-1:0] total,
  input  logic [IDXW-1:0] vstart,
  output logic            idle,
  output logic            run,
  output logic [IDXW-1:0] idx,
  output logic            done,
  output logic            vstart_clr,
  output logic            ill_flag
);
  import vpol_pkg::*;

  vpol_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      idx        <= '0;
      done       <= 1'b0;
      vstart_clr <= 1'b0;
      ill_flag   <= 1'b0;
    end else begin
      done       <= 1'b0;
      vstart_clr <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q  <= ST_SETUP;
            ill_flag <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (illegal) begin
            state_q  <= ST_IDLE;
            done     <= 1'b1;
            ill_flag <= 1'b1;
          end else if (vstart >= total) begin
            state_q    <= ST_IDLE;
            done       <= 1'b1;
            vstart_clr <= 1'b1;
          end else begin
            state_q <= ST_RUN;
            idx     <= vstart;
          end
        end
        ST_RUN: begin
          idx <= idx + IDXW'(1);
          if (idx == total - IDXW'(1)) begin
            state_q    <= ST_IDLE;
            done       <= 1'b1;
            vstart_clr <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle = (state_q == ST_IDLE);
  assign run  = (state_q == ST_RUN);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idx_in_group_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (idx < total));
  assert_clear_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vstart_clr |-> done);
  assert_illegal_no_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ill_flag) |-> !vstart_clr);
  assert_illegal_never_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !illegal);
endmodule

// File: rtl/vpol_engine.sv
module vpol_engine #(
  parameter int VLENB      = 16,
  parameter int MAX_LMUL_L = 3
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      req_valid,
  output logic                                      req_ready,
  input  logic [$clog2((VLENB<<MAX_LMUL_L)+1)-1:0]  cfg_vstart,
  input  logic [$clog2((VLENB<<MAX_LMUL_L)+1)-1:0]  cfg_vl,
  input  logic                                      cfg_vm,
  input  logic                                      cfg_vma,
  input  logic                                      cfg_vta,
  input  logic [2:0]                                cfg_lmul,
  input  logic [1:0]                                cfg_sew_l,
  input  logic [1:0]                                cfg_esz_l,
  input  logic [1:0]                                cfg_op,
  input  logic [63:0]                               scalar_in,
  input  logic [(VLENB<<MAX_LMUL_L)-1:0]            mask_in,
  input  logic [8*(VLENB<<MAX_LMUL_L)-1:0]          vs1_in,
  input  logic [8*(VLENB<<MAX_LMUL_L)-1:0]          vs2_in,
  input  logic [8*(VLENB<<MAX_LMUL_L)-1:0]          vd_in,
  output logic [8*(VLENB<<MAX_LMUL_L)-1:0]          vd_out,
  output logic                                      done,
  output logic                                      vstart_clr,
  output logic                                      cfg_illegal
);
  localparam int GRP_BYTES = VLENB << MAX_LMUL_L;
  localparam int MAX_ELEMS = GRP_BYTES;
  localparam int IDXW      = $clog2(MAX_ELEMS + 1);
  localparam int AW        = $clog2(GRP_BYTES);
  localparam int LANES     = 8;

  logic [7:0] vs1_q [GRP_BYTES];
  logic [7:0] vs2_q [GRP_BYTES];
  logic [7:0] vd_q  [GRP_BYTES];
  logic [MAX_ELEMS-1:0] mask_q;
  logic [IDXW-1:0] vstart_q, vl_q;
  logic            vm_q, vma_q, vta_q;
  logic [2:0]      lmul_q;
  logic [1:0]      sew_q, esz_q, op_q;
  logic [63:0]     scalar_q;

  logic            idle, run, accept;
  logic [IDXW-1:0] idx, total;
  logic            illegal;
  logic [63:0]     a_el, b_el, wdata;
  logic            wr_en, in_body, el_active;
  logic [LANES-1:0] lane_en;
  logic [AW-1:0]   lane_addr [LANES];
  int              base_off;
  int              nbytes;

  assign req_ready = idle;
  assign accept    = req_valid && idle;

  vpol_geom #(.VLENB(VLENB), .MAX_LMUL_L(MAX_LMUL_L), .IDXW(IDXW)) u_geom (
    .lmul(lmul_q), .sew_l(sew_q), .esz_l(esz_q), .total(total), .illegal(illegal)
  );

  vpol_seq #(.IDXW(IDXW)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .illegal(illegal),
    .total(total), .vstart(vstart_q), .idle(idle), .run(run), .idx(idx),
    .done(done), .vstart_clr(vstart_clr), .ill_flag(cfg_illegal)
  );

  // Gather the current element's bytes from both sources.
  always_comb begin
    nbytes   = 1 << esz_q;
    base_off = int'(idx) << esz_q;
    a_el     = '0;
    b_el     = '0;
    for (int k = 0; k < LANES; k++) begin
      lane_en[k]   = 1'b0;
      lane_addr[k] = '0;
      if (k < nbytes && (base_off + k) < GRP_BYTES) begin
        lane_addr[k]   = AW'(base_off + k);
        lane_en[k]     = run && wr_en;
        a_el[8*k +: 8] = vs2_q[AW'(base_off + k)];
        b_el[8*k +: 8] = vs1_q[AW'(base_off + k)];
      end
    end
    in_body   = (idx < vl_q);
    el_active = vm_q || mask_q[idx[AW:0]];
  end

  vpol_lane u_lane (
    .a_el(a_el), .b_el(b_el), .scalar(scalar_q), .op(op_q), .esz_l(esz_q),
    .in_body(in_body), .el_active(el_active), .vma(vma_q), .vta(vta_q),
    .wr_en(wr_en), .wdata(wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < GRP_BYTES; b++) begin
        vd_q[b]  <= '0;
        vs1_q[b] <= '0;
        vs2_q[b] <= '0;
      end
      mask_q   <= '0;
      vstart_q <= '0;
      vl_q     <= '0;
      vm_q     <= 1'b1;
      vma_q    <= 1'b0;
      vta_q    <= 1'b0;
      lmul_q   <= '0;
      sew_q    <= '0;
      esz_q    <= '0;
      op_q     <= '0;
      scalar_q <= '0;
    end else if (accept) begin
      for (int b = 0; b < GRP_BYTES; b++) begin
        vd_q[b]  <= vd_in[8*b +: 8];
        vs1_q[b] <= vs1_in[8*b +: 8];
        vs2_q[b] <= vs2_in[8*b +: 8];
      end
      mask_q   <= mask_in;
      vstart_q <= cfg_vstart;
      vl_q     <= cfg_vl;
      vm_q     <= cfg_vm;
      vma_q    <= cfg_vma;
      vta_q    <= cfg_vta;
      lmul_q   <= cfg_lmul;
      sew_q    <= cfg_sew_l;
      esz_q    <= cfg_esz_l;
      op_q     <= cfg_op;
      scalar_q <= scalar_in;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (lane_en[k]) vd_q[lane_addr[k]] <= wdata[8*k +: 8];
      end
    end
  end

  always_comb begin
    for (int b = 0; b < GRP_BYTES; b++) vd_out[8*b +: 8] = vd_q[b];
  end

  assert_result_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !accept) |=> $stable(vd_out));
  assert_total_pow2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ($countones(total) == 1));
endmodule

// File: tb/vpol_engine_tb.sv
module vpol_engine_tb;
  localparam int VLENB = 16;
  localparam int MAXL  = 3;
  localparam int GB    = VLENB << MAXL;
  localparam int IDXW  = $clog2(GB + 1);
  localparam logic [63:0] SCALAR = 64'h1234_5678_9ABC_DEF1;

  typedef struct packed {
    logic [7:0]  vstart;
    logic [7:0]  vl;
    logic        vm;
    logic        vma;
    logic        vta;
    logic [2:0]  lmul;
    logic [1:0]  sew_l;
    logic [1:0]  esz_l;
    logic [1:0]  op;
    logic [15:0] mseed;
  } tc_t;

  // vstart, vl, vm, vma, vta, lmul, sew, esz, op, mask seed
  localparam int NT = 11;
  localparam tc_t TBL [NT] = '{
    '{8'd0,  8'd16,  1'b1, 1'b0, 1'b0, 3'b000, 2'd0, 2'd0, 2'd1, 16'hFFFF}, // R4 add e8
    '{8'd0,  8'd10,  1'b0, 1'b1, 1'b1, 3'b000, 2'd0, 2'd0, 2'd2, 16'hA5C3}, // R5 R6 agnostic
    '{8'd0,  8'd9,   1'b0, 1'b0, 1'b0, 3'b001, 2'd1, 2'd1, 2'd3, 16'h3C96}, // R5 R6 undisturbed
    '{8'd1,  8'd3,   1'b1, 1'b0, 1'b1, 3'b000, 2'd2, 2'd2, 2'd1, 16'h0000}, // R3 prestart e32
    '{8'd0,  8'd12,  1'b0, 1'b1, 1'b1, 3'b011, 2'd3, 2'd3, 2'd0, 16'hF0F0}, // R8 e64 m8
    '{8'd0,  8'd5,   1'b1, 1'b0, 1'b1, 3'b111, 2'd0, 2'd0, 2'd1, 16'h0000}, // R7 fractional
    '{8'd3,  8'd100, 1'b0, 1'b1, 1'b0, 3'b011, 2'd0, 2'd0, 2'd2, 16'h6D2B}, // R5 m8 e8
    '{8'd8,  8'd4,   1'b1, 1'b0, 1'b1, 3'b000, 2'd1, 2'd1, 2'd1, 16'h0000}, // R10
    '{8'd0,  8'd16,  1'b1, 1'b0, 1'b0, 3'b011, 2'd0, 2'd3, 2'd3, 16'h0000}, // R7 upper clamp
    '{8'd0,  8'd0,   1'b1, 1'b0, 1'b1, 3'b111, 2'd3, 2'd0, 2'd1, 16'h0000}, // R7 lower clamp
    '{8'd20, 8'd30,  1'b1, 1'b0, 1'b1, 3'b000, 2'd2, 2'd2, 2'd1, 16'h0000}  // R2 vstart past total
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [IDXW-1:0] cfg_vstart = '0, cfg_vl = '0;
  logic cfg_vm = 1'b1, cfg_vma = 1'b0, cfg_vta = 1'b0;
  logic [2:0] cfg_lmul = '0;
  logic [1:0] cfg_sew_l = '0, cfg_esz_l = '0, cfg_op = '0;
  logic [63:0] scalar_in = SCALAR;
  logic [GB-1:0] mask_in = '0;
  logic [8*GB-1:0] vs1_in, vs2_in, vd_in, vd_out;
  logic done, vstart_clr, cfg_illegal;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_b [GB];

  always #5 clk = ~clk;

  vpol_engine #(.VLENB(VLENB), .MAX_LMUL_L(MAXL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cfg_vstart(cfg_vstart), .cfg_vl(cfg_vl), .cfg_vm(cfg_vm), .cfg_vma(cfg_vma),
    .cfg_vta(cfg_vta), .cfg_lmul(cfg_lmul), .cfg_sew_l(cfg_sew_l),
    .cfg_esz_l(cfg_esz_l), .cfg_op(cfg_op), .scalar_in(scalar_in),
    .mask_in(mask_in), .vs1_in(vs1_in), .vs2_in(vs2_in), .vd_in(vd_in),
    .vd_out(vd_out), .done(done), .vstart_clr(vstart_clr), .cfg_illegal(cfg_illegal)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int m_total(input tc_t c);
    int lm, e;
    lm = c.lmul[2] ? int'(c.lmul) - 8 : int'(c.lmul);
    e  = int'(c.esz_l) - int'(c.sew_l) + lm;
    if (e < 0) e = 0;
    if (e > MAXL) e = MAXL;
    return (VLENB << e) >> c.esz_l;
  endfunction

  function automatic int m_cycles(input tc_t c);
    int t;
    if (c.lmul == 3'b100) return 2;
    t = m_total(c);
    return (int'(c.vstart) < t) ? (t - int'(c.vstart) + 2) : 2;
  endfunction

  task automatic build_expected(input tc_t c);
    int t, nb;
    logic [63:0] a, b, wm, r;
    logic body, act, wr, fill;
    for (int i = 0; i < GB; i++) exp_b[i] = vd_in[8*i +: 8];
    if (c.lmul == 3'b100) return;
    t  = m_total(c);
    nb = 1 << c.esz_l;
    wm = (nb == 8) ? '1 : ((64'd1 << (8 * nb)) - 64'd1);
    for (int i = int'(c.vstart); i < t; i++) begin
      a = '0; b = '0;
      for (int k = 0; k < nb; k++) begin
        a = a | (64'(vs2_in[8*(i*nb+k) +: 8]) << (8 * k));
        b = b | (64'(vs1_in[8*(i*nb+k) +: 8]) << (8 * k));
      end
      case (c.op)
        2'd0: r = a;
        2'd1: r = a + b;
        2'd2: r = a - b;
        default: r = a - (SCALAR & wm);
      endcase
      body = (i < int'(c.vl));
      act  = c.vm || mask_in[i];
      if (body) begin wr = act || c.vma; fill = !act; end
      else begin wr = c.vta; fill = 1'b1; end
      if (wr) for (int k = 0; k < nb; k++)
        exp_b[i*nb+k] = fill ? 8'hFF : r[8*k +: 8];
    end
  endtask

  task automatic drive_req(input tc_t c);
    cfg_vstart = IDXW'(c.vstart);
    cfg_vl     = IDXW'(c.vl);
    cfg_vm     = c.vm;
    cfg_vma    = c.vma;
    cfg_vta    = c.vta;
    cfg_lmul   = c.lmul;
    cfg_sew_l  = c.sew_l;
    cfg_esz_l  = c.esz_l;
    cfg_op     = c.op;
    mask_in    = {8{c.mseed}};
    build_expected(c);
    req_valid  = 1'b1;
  endtask

  // Called right after drive_req, at a falling edge while idle.
  task automatic finish_job(input tc_t c, input string tag);
    int cyc;
    int bad;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    chk(req_ready == 1'b0, "R1", {tag, " ready low while busy"}, 64'(req_ready), 64'd0);
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == m_cycles(c), "R2", {tag, " done latency"}, 64'(cyc), 64'(m_cycles(c)));
    chk(vstart_clr == (c.lmul != 3'b100), "R3", {tag, " vstart_clr with done"},
        64'(vstart_clr), 64'(c.lmul != 3'b100));
    chk(cfg_illegal == (c.lmul == 3'b100), "R9", {tag, " illegal flag"},
        64'(cfg_illegal), 64'(c.lmul == 3'b100));
    bad = -1;
    for (int i = GB - 1; i >= 0; i--) if (vd_out[8*i +: 8] !== exp_b[i]) bad = i;
    if (bad < 0) chk(1'b1, "R4", {tag, " group data"}, 0, 0);
    else chk(1'b0, "R4/R5/R6/R8", {tag, " group byte mismatch"},
             64'(vd_out[8*bad +: 8]), 64'(exp_b[bad]));
  endtask

  initial begin
    for (int i = 0; i < GB; i++) begin
      vs2_in[8*i +: 8] = 8'(i * 37 + 11);
      vs1_in[8*i +: 8] = 8'(i * 91 + 5);
      vd_in[8*i +: 8]  = 8'h5A ^ 8'(i * 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11", "ready after reset", 64'(req_ready), 64'd1);
    chk(done == 1'b0 && vstart_clr == 1'b0, "R11", "pulses low after reset",
        64'({done, vstart_clr}), 64'd0);
    chk(cfg_illegal == 1'b0, "R11", "illegal low after reset", 64'(cfg_illegal), 64'd0);
    chk(vd_out == '0, "R11", "vd_out zero after reset", vd_out[63:0], 64'd0);

    for (int t = 0; t < NT; t++) begin
      @(negedge clk);
      drive_req(TBL[t]);
      finish_job(TBL[t], $sformatf("case%0d", t));
    end

    // R1: result held while idle
    begin
      logic [8*GB-1:0] snap;
      snap = vd_out;
      repeat (4) @(negedge clk);
      chk(vd_out == snap, "R1", "result held while idle", vd_out[63:0], snap[63:0]);
      chk(req_ready == 1'b1, "R1", "ready while idle", 64'(req_ready), 64'd1);
    end

    // R9: reserved lmul code leaves the group untouched
    begin
      tc_t ill;
      ill = '{8'd0, 8'd2, 1'b1, 1'b1, 1'b1, 3'b100, 2'd0, 2'd0, 2'd1, 16'h0000};
      @(negedge clk);
      drive_req(ill);
      finish_job(ill, "illegal");
    end

    // R1 R2: new request taken in the done cycle of the previous job
    @(negedge clk);
    drive_req(TBL[1]);
    finish_job(TBL[1], "b2b_first");
    drive_req(TBL[3]);
    finish_job(TBL[3], "b2b_second");
    chk(cfg_illegal == 1'b0, "R9", "illegal cleared by next legal job", 64'(cfg_illegal), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule